// File: doc/BRIEF.md
# Block-Transfer Address Sequencer

This block turns one multi-register memory transfer into a stream of single-word accesses. A start pulse captures a register selection mask, a base address, an ordering mode and a writeback flag. The block then issues one register index and one word address per accepted beat on a valid/ready handshake. When the last beat is accepted, it pulses a completion strobe and presents the updated base value.

Registers are always issued lowest-numbered first, at ascending word addresses. The ordering mode picks whether the range grows upward or downward from the base, and whether the base is stepped before or after each access. The moved data, register-file reads and writes, and memory traffic are handled elsewhere.

Top module: `lsm_addr_seq`

## Requirements
- R1: While reset is held, and in the cycle after it is released, `valid_o` and `done_o` are 0.
- R2: One beat is issued for each set bit of the mask. Register indices come in strictly ascending order, each equal to the position of a set mask bit.
- R3: Mode 2'b00 (grow up, step after): the first beat address is the base, and each later beat is 4 above the previous one.
- R4: Mode 2'b01 (grow up, step before): the first beat address is base + 4, and each later beat is 4 above the previous one.
- R5: Mode 2'b10 (grow down, step after): the first beat address is base − 4·N + 4, where N is the number of set mask bits. Each later beat is 4 above the previous one.
- R6: Mode 2'b11 (grow down, step before): the first beat address is base − 4·N, and each later beat is 4 above the previous one.
- R7: At `done_o`, `base_out_o` is base + 4·N when `wb_en_i` is 1 and mode bit 1 is 0. It is base − 4·N when `wb_en_i` is 1 and mode bit 1 is 1. It is the unchanged base when `wb_en_i` is 0.
- R8: An all-zero mask produces no beat. `done_o` pulses in the cycle after the start, and `base_out_o` equals the base.
- R9: While `valid_o` is 1 and `ready_i` is 0, `valid_o`, `reg_idx_o` and `addr_o` hold their values into the next cycle.
- R10: A start pulse that arrives while a transfer is in progress is ignored: the beats of the current transfer continue unchanged.
- R11: `valid_o` rises in the cycle after an accepted start with a non-zero mask. `done_o` pulses for one cycle, in the cycle after the last beat is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Start pulse, accepted when no transfer is in progress |
| mask_i | input | 16 | Register selection mask |
| base_i | input | 32 | Base address |
| mode_i | input | 2 | Bit 1: grow down; bit 0: step before |
| wb_en_i | input | 1 | Report the stepped base when 1 |
| ready_i | input | 1 | Consumer accepts the current beat |
| valid_o | output | 1 | Beat valid; high for the whole transfer |
| reg_idx_o | output | 4 | Register index of the current beat |
| addr_o | output | 32 | Word address of the current beat |
| done_o | output | 1 | One-cycle completion strobe |
| base_out_o | output | 32 | Updated base, valid from `done_o` onward |

## Verification
The bench aims at the four orderings with a single-register mask and a full mask. A design with the wrong pre-offset or span shows up there as an address off by 4 or by the whole span. An all-zero mask catches a design that issues a phantom beat for register 0 or never finishes. Random back-pressure, together with a start pulse injected in the middle of a transfer, exposes beats that advance without acceptance or a transfer that restarts on a new command. Transfers with writeback off catch a base that is stepped when it should not be.

// File: rtl/lsm_pkg.sv
// Shared types for the block-transfer address sequencer.
// Assumes the mode encoding: bit 1 selects a downward range, bit 0 selects
// stepping the base before the access.
package lsm_pkg;

    typedef enum logic [1:0] {
        LSM_UP_AFTER    = 2'b00,
        LSM_UP_BEFORE   = 2'b01,
        LSM_DOWN_AFTER  = 2'b10,
        LSM_DOWN_BEFORE = 2'b11
    } lsm_mode_e;

endpackage

// File: rtl/lsm_popcount.sv
// Counts the set bits of a register mask.
// Assumes CW is wide enough to hold the value NREG.
module lsm_popcount #(
    parameter int NREG = 16,
    parameter int CW   = $clog2(NREG + 1)
) (
    input  logic [NREG-1:0] vec_i,
    output logic [CW-1:0]   cnt_o
);

    // Sum every bit of the mask.
    always_comb begin
        cnt_o = '0;
        for (int i = 0; i < NREG; i++) begin
            cnt_o = cnt_o + CW'(vec_i[i]);
        end
    end

endmodule

// File: rtl/lsm_low_index.sv
// Finds the position of the lowest set bit of a mask.
// Assumes the caller qualifies the result with a non-zero mask; for a zero
// mask the index reads as 0 and found_o is 0.
module lsm_low_index #(
    parameter int NREG = 16,
    parameter int IW   = $clog2(NREG)
) (
    input  logic [NREG-1:0] vec_i,
    output logic [IW-1:0]   idx_o,
    output logic            found_o
);

    // Scan from the top so that the lowest set bit wins.
    always_comb begin
        idx_o   = '0;
        found_o = 1'b0;
        for (int i = NREG - 1; i >= 0; i--) begin
            if (vec_i[i]) begin
                idx_o   = IW'(i);
                found_o = 1'b1;
            end
        end
    end

endmodule

// File: rtl/lsm_addr_plan.sv
// Works out the first beat address and the final base of a transfer
// from the base, the beat count and the ordering mode.
// Assumes arithmetic wraps modulo 2**AW.
module lsm_addr_plan
    import lsm_pkg::*;
#(
    parameter int AW         = 32,
    parameter int CW         = 5,
    parameter int WORD_BYTES = 4
) (
    input  logic [AW-1:0] base_i,
    input  logic [CW-1:0] cnt_i,
    input  lsm_mode_e     mode_i,
    input  logic          wb_en_i,
    output logic [AW-1:0] first_o,
    output logic [AW-1:0] final_o
);

    localparam logic [AW-1:0] STEP = AW'(WORD_BYTES);

    logic [AW-1:0] span;

    // Byte size of the whole range.
    always_comb span = AW'(cnt_i) * STEP;

    // Lowest address of the range, per ordering.
    always_comb begin
        unique case (mode_i)
            LSM_UP_AFTER:    first_o = base_i;
            LSM_UP_BEFORE:   first_o = base_i + STEP;
            LSM_DOWN_AFTER:  first_o = base_i - span + STEP;
            LSM_DOWN_BEFORE: first_o = base_i - span;
            default:         first_o = base_i;
        endcase
    end

    // Base reported at completion.
    always_comb begin
        if (!wb_en_i)
            final_o = base_i;
        else if (mode_i[1])
            final_o = base_i - span;
        else
            final_o = base_i + span;
    end

endmodule

// File: rtl/lsm_addr_seq.sv
// Top of the block-transfer address sequencer.
// On a start pulse with no transfer in progress, it captures the command
// and issues one beat per selected register, lowest index first, at
// ascending word addresses. Beats hold until accepted, and a completion
// strobe follows the last one.
// Assumes a start pulse that arrives during a transfer is dropped.
module lsm_addr_seq
    import lsm_pkg::*;
#(
    parameter int NREG       = 16,
    parameter int AW         = 32,
    parameter int WORD_BYTES = 4,
    localparam int IW        = $clog2(NREG),
    localparam int CW        = $clog2(NREG + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [NREG-1:0] mask_i,
    input  logic [AW-1:0]   base_i,
    input  logic [1:0]      mode_i,
    input  logic            wb_en_i,
    input  logic            ready_i,
    output logic            valid_o,
    output logic [IW-1:0]   reg_idx_o,
    output logic [AW-1:0]   addr_o,
    output logic            done_o,
    output logic [AW-1:0]   base_out_o
);

    localparam logic [AW-1:0] STEP = AW'(WORD_BYTES);

    logic [NREG-1:0] rem_q;
    logic [AW-1:0]   addr_q;
    logic [AW-1:0]   fin_q;
    logic            busy_q;
    logic            done_q;
    logic [AW-1:0]   base_q;

    logic [CW-1:0]   cnt;
    logic [AW-1:0]   first_addr;
    logic [AW-1:0]   final_base;
    logic [IW-1:0]   low_idx;
    logic            low_found;
    logic            take_start;
    logic            beat_fire;
    logic            last_beat;
    logic [NREG-1:0] rem_next;

    lsm_popcount #(.NREG(NREG), .CW(CW)) u_count (
        .vec_i (mask_i),
        .cnt_o (cnt)
    );

    lsm_addr_plan #(.AW(AW), .CW(CW), .WORD_BYTES(WORD_BYTES)) u_plan (
        .base_i  (base_i),
        .cnt_i   (cnt),
        .mode_i  (lsm_mode_e'(mode_i)),
        .wb_en_i (wb_en_i),
        .first_o (first_addr),
        .final_o (final_base)
    );

    lsm_low_index #(.NREG(NREG), .IW(IW)) u_low (
        .vec_i   (rem_q),
        .idx_o   (low_idx),
        .found_o (low_found)
    );

    // Handshake and end-of-transfer decode.
    always_comb begin
        take_start = start_i && !busy_q;
        beat_fire  = busy_q && ready_i;
        rem_next   = rem_q & (rem_q - NREG'(1));
        last_beat  = (rem_next == '0);
    end

    // Transfer state: remaining mask, current address and pending base.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q <= 1'b0;
            rem_q  <= '0;
            addr_q <= '0;
            fin_q  <= '0;
        end else if (take_start) begin
            busy_q <= (mask_i != '0);
            rem_q  <= mask_i;
            addr_q <= first_addr;
            fin_q  <= final_base;
        end else if (beat_fire) begin
            busy_q <= !last_beat;
            rem_q  <= rem_next;
            addr_q <= addr_q + STEP;
        end
    end

    // Completion strobe and reported base.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            done_q <= 1'b0;
            base_q <= '0;
        end else if (take_start && mask_i == '0) begin
            done_q <= 1'b1;
            base_q <= final_base;
        end else if (beat_fire && last_beat) begin
            done_q <= 1'b1;
            base_q <= fin_q;
        end else begin
            done_q <= 1'b0;
        end
    end

    // Drive the outputs; a valid beat always has a remaining register.
    always_comb begin
        valid_o    = busy_q && low_found;
        reg_idx_o  = low_idx;
        addr_o     = addr_q;
        done_o     = done_q;
        base_out_o = base_q;
    end

endmodule

// File: rtl/lsm_addr_seq_chk.sv
// Checker for the block-transfer address sequencer, attached with bind.
// Assumes it sees the top-level ports only.
module lsm_addr_seq_chk #(
    parameter int NREG = 16,
    parameter int AW   = 32,
    parameter int IW   = 4
) (
    input logic          clk,
    input logic          rst_n,
    input logic          start_i,
    input logic          ready_i,
    input logic          valid_o,
    input logic [IW-1:0] reg_idx_o,
    input logic [AW-1:0] addr_o,
    input logic          done_o
);

    // R1
    reset_quiet_chk: assert property (@(posedge clk)
        !rst_n |=> (!valid_o && !done_o));

    // R9
    beat_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !ready_i) |=> (valid_o && $stable(reg_idx_o) && $stable(addr_o)));

    // R2
    idx_ascend_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && ready_i) |=> (!valid_o || (reg_idx_o > $past(reg_idx_o))));

    // R3
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && ready_i) |=> (!valid_o || (addr_o == $past(addr_o) + AW'(4))));

    // R11
    valid_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(valid_o) |-> $past(start_i));

    // R11
    done_not_with_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !valid_o);

    // R10
    busy_start_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (valid_o && !ready_i && start_i) |=> (valid_o && $stable(addr_o)));

endmodule

bind lsm_addr_seq lsm_addr_seq_chk #(.NREG(NREG), .AW(AW), .IW(IW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_i   (start_i),
    .ready_i   (ready_i),
    .valid_o   (valid_o),
    .reg_idx_o (reg_idx_o),
    .addr_o    (addr_o),
    .done_o    (done_o)
);

// File: tb/test_lsm_addr_seq.sv
// Bench for lsm_addr_seq: directed corner cases plus seeded random transfers.
module test_lsm_addr_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [15:0] mask_i = '0;
    logic [31:0] base_i = '0;
    logic [1:0]  mode_i = '0;
    logic        wb_en_i = 1'b0;
    logic        ready_i = 1'b0;
    logic        valid_o;
    logic [3:0]  reg_idx_o;
    logic [31:0] addr_o;
    logic        done_o;
    logic [31:0] base_out_o;

    int n_run = 0;
    int n_fail = 0;
    int cycles = 0;

    always #4 clk = ~clk;

    lsm_addr_seq i_lsm_addr_seq (
        .clk (clk), .rst_n (rst_n), .start_i (start_i), .mask_i (mask_i),
        .base_i (base_i), .mode_i (mode_i), .wb_en_i (wb_en_i),
        .ready_i (ready_i), .valid_o (valid_o), .reg_idx_o (reg_idx_o),
        .addr_o (addr_o), .done_o (done_o), .base_out_o (base_out_o)
    );

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    function automatic int pop16(input logic [15:0] m);
        int c = 0;
        for (int i = 0; i < 16; i++) c += int'(m[i]);
        return c;
    endfunction

    function automatic logic [3:0] low16(input logic [15:0] m);
        for (int i = 0; i < 16; i++) if (m[i]) return 4'(i);
        return 4'd0;
    endfunction

    function automatic logic [31:0] exp_first(input logic [31:0] b, input int n, input logic [1:0] md);
        logic [31:0] span = 32'(n) * 32'd4;
        case (md)
            2'b00:   return b;
            2'b01:   return b + 32'd4;
            2'b10:   return b - span + 32'd4;
            default: return b - span;
        endcase
    endfunction

    function automatic logic [31:0] exp_final(input logic [31:0] b, input int n, input logic [1:0] md, input logic wb);
        if (!wb) return b;
        return md[1] ? b - 32'(n) * 32'd4 : b + 32'(n) * 32'd4;
    endfunction

    function automatic string mode_req(input logic [1:0] md);
        case (md)
            2'b00:   return "R3";
            2'b01:   return "R4";
            2'b10:   return "R5";
            default: return "R6";
        endcase
    endfunction

    task automatic run_op(input logic [15:0] m, input logic [31:0] b, input logic [1:0] md,
                          input logic wb, input bit poke);
        int n = pop16(m);
        logic [31:0] a0 = exp_first(b, n, md);
        logic [15:0] r = m;
        int k = 0;
        int guard = 0;
        bit fin = 0;
        @(negedge clk);
        start_i = 1'b1; mask_i = m; base_i = b; mode_i = md; wb_en_i = wb; ready_i = 1'b0;
        @(negedge clk);
        start_i = 1'b0;
        if (n == 0) begin
            check(done_o == 1'b1, "R8 done", 32'(done_o), 1);
            check(valid_o == 1'b0, "R8 valid", 32'(valid_o), 0);
            check(base_out_o == b, "R8 base", base_out_o, b);
            @(negedge clk);
            check(done_o == 1'b0 && valid_o == 1'b0, "R11 single done", 32'(done_o), 0);
            return;
        end
        check(valid_o == 1'b1, "R11 valid rise", 32'(valid_o), 1);
        while (!fin && guard < 400) begin
            if (done_o) begin
                fin = 1;
                check(k == n, "R2 beat count", 32'(k), 32'(n));
                check(base_out_o == exp_final(b, n, md, wb), "R7 base", base_out_o, exp_final(b, n, md, wb));
            end else if (valid_o) begin
                check(k < n, "R2 extra beat", 32'(k), 32'(n));
                check(reg_idx_o == low16(r), "R2 index", 32'(reg_idx_o), 32'(low16(r)));
                check(addr_o == a0 + 32'(k) * 32'd4, mode_req(md), addr_o, a0 + 32'(k) * 32'd4);
                ready_i = 1'($urandom % 2);
                if (!ready_i && poke) begin
                    start_i = 1'b1; mask_i = ~m; base_i = ~b; mode_i = ~md;  // R10
                end else begin
                    start_i = 1'b0;
                end
                if (ready_i) begin
                    k++;
                    r = r & (r - 16'd1);
                end
                @(negedge clk);
                start_i = 1'b0;
                guard++;
                continue;
            end else begin
                check(1'b0, "R11 gap", 32'(valid_o), 1);
                fin = 1;
            end
            @(negedge clk);
            guard++;
        end
        check(fin, "R11 completion", 32'(fin), 1);
        ready_i = 1'b0;
        @(negedge clk);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=%0d expected=<150000", cycles);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        check(valid_o == 1'b0 && done_o == 1'b0, "R1 in reset", 32'({valid_o, done_o}), 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(valid_o == 1'b0 && done_o == 1'b0, "R1 after reset", 32'({valid_o, done_o}), 0);

        for (int md = 0; md < 4; md++) begin
            run_op(16'h0001, 32'h0000_1000, 2'(md), 1'b1, 1'b0);
            run_op(16'h8000, 32'h0000_2000, 2'(md), 1'b1, 1'b0);
            run_op(16'hFFFF, 32'h0000_4000, 2'(md), 1'b1, 1'b1);
            run_op(16'h8001, 32'h0000_0010, 2'(md), 1'b0, 1'b0);
            run_op(16'h0000, 32'h0000_3000, 2'(md), 1'b1, 1'b0);
        end
        run_op(16'h00F0, 32'h0000_0000, 2'b11, 1'b1, 1'b1);  // wrap below zero

        for (int t = 0; t < 300; t++) begin
            logic [15:0] m = 16'($urandom);
            if (t % 17 == 0) m = '0;
            run_op(m, {$urandom} & 32'hFFFF_FFFC, 2'($urandom), 1'($urandom), 1'($urandom));
        end

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule